// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block is the optional 32-byte payload store that sits behind the block data port of an SMBus host controller. When buffer mode is on, software loads a whole block-write payload into it before the transaction starts. After a block read completes, software empties the whole received payload from it. In both cases all bytes pass through one register offset, which steps through the buffer by itself. The byte count is kept in the data0 register. The bus engine, which is a separate sequencer, reads this count and exchanges payload bytes with the store over a simple byte stream.

A read of the control register sends the software index back to entry 0. Buffer mode is switched on by bit 1 of an auxiliary control register, and that bit reads back as 1 only when the buffer is actually built. Bit 0 of the same register enables hardware PEC and is passed straight to the engine. Buffer mode is used only for SMBus block transfers. When an I2C block transfer is selected, or when buffer mode is off, the block data port acts as a single byte register and does not step.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, data0 reads 0, the auxiliary register reads 0, pec_en is 0 and proto_fail is 0.
- R2: A write to the auxiliary register (offset 13) stores bit 0 as PEC enable, which drives pec_en, and bit 1 as buffer enable. Both read back in the same bit positions at offset 13, and writing 0 clears both.
- R3: Any read of the control register (offset 2) sets the software index to entry 0, so the next block data port access uses the first entry.
- R4: In buffer mode (auxiliary bit 1 = 1, blk_i2c = 0), successive writes to the block data port (offset 7) fill consecutive entries. After eng_start, successive eng_tx_pop cycles present those bytes in order on eng_tx_byte, and data0 (offset 5), written by software, appears on eng_count.
- R5: In buffer mode, an eng_rx_valid byte with eng_rx_first = 1 is stored into data0. The payload bytes that follow are stored in order, and software reads them back in order at offset 7 after a control register read.
- R6: A received count of 0 or above 32 sets proto_fail from the next cycle. A count of 1 to 32 leaves it clear, and eng_start clears it.
- R7: After 32 port accesses the software index stays past the end. Further writes change nothing, and further reads return 0. Received payload bytes beyond the 32nd are not stored, and pops beyond the 32nd return 0.
- R8: With blk_i2c = 1 or buffer mode off, the block data port is a single byte register. A read returns the last byte written, and no access moves the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 4 | Register offset of the current access |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (has side effects) |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, combinational from the current state |
| blk_i2c | input | 1 | 1 when the pending block transfer is I2C style |
| eng_start | input | 1 | Engine begins a transaction; rewinds the engine index |
| eng_tx_pop | input | 1 | Engine consumes one write payload byte |
| eng_tx_byte | output | 8 | Payload byte offered to the engine |
| eng_rx_valid | input | 1 | Engine delivers one received byte |
| eng_rx_first | input | 1 | The delivered byte is the count |
| eng_rx_byte | input | 8 | Received byte |
| eng_count | output | 8 | Current data0 value (byte count) |
| pec_en | output | 1 | Hardware PEC enable |
| proto_fail | output | 1 | Received count out of range |

## Verification
Read data at offset 7 and eng_tx_byte are due in the same cycle as the strobe. Index movement, data0, the auxiliary bits and proto_fail take effect at the rising edge that closes the strobe cycle. The bench drives each strobe just after a falling edge and samples combinational results 1 ns later, before the rising edge. It samples registered results after the following falling edge, once exactly one rising edge has passed. Payload lengths and bytes are drawn at random, and the end cases are directed: counts of 0, 32 and 33, and accesses past the 32nd entry.

// File: rtl/smbb_pkg.sv
// Shared constants for the SMBus block buffer: register offsets decoded
// by the buffer and bit positions inside the auxiliary control register.
package smbb_pkg;
    localparam int OFS_CTRL  = 2;    // control register: read rewinds index
    localparam int OFS_DATA0 = 5;    // byte count register
    localparam int OFS_PORT  = 7;    // block data port
    localparam int OFS_AUX   = 13;   // auxiliary control register
    localparam int AUX_PEC_BIT = 0;
    localparam int AUX_BUF_BIT = 1;
endpackage

// File: rtl/smbb_index.sv
// Saturating buffer index. Counts 0..DEPTH-1; a step taken at the last
// entry sets past_end instead of wrapping, and later steps are ignored.
// Assumes clr and step are never both needed in one cycle (clr wins).
module smbb_index #(
    parameter int DEPTH = 32,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          past_end
);
    // Advance, saturate or rewind the index
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx      <= '0;
            past_end <= 1'b0;
        end else if (step && !past_end) begin
            if (idx == IW'(DEPTH - 1)) begin
                past_end <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbb_store.sv
// Payload storage: DEPTH entries of DW bits, one write port and two
// combinational read ports (software side and engine side).
// Assumes read addresses stay below DEPTH.
module smbb_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Load one entry when addressed by the write port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (we && (waddr == IW'(i))) begin
                mem_q[i] <= wdata;
            end
        end
    end

    // Two independent read ports
    always_comb begin
        rdata_a = mem_q[raddr_a];
        rdata_b = mem_q[raddr_b];
    end
endmodule

// File: rtl/smbb_regs.sv
// Count register, auxiliary control bits and the count-range failure flag.
// A count delivered by the engine overrides a software data0 write in the
// same cycle; a bad count arriving with eng_start still sets the flag.
// Assumes DEPTH fits in DW bits.
module smbb_regs #(
    parameter int DW          = 8,
    parameter int DEPTH       = 32,
    parameter bit BUF_PRESENT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          aux_we,
    input  logic          data0_we,
    input  logic [DW-1:0] wdata,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_in,
    input  logic          start,
    output logic          aux_pec,
    output logic          aux_buf,
    output logic [DW-1:0] data0,
    output logic          proto_fail
);
    import smbb_pkg::*;

    logic cnt_bad;

    // Range test on a received count
    always_comb begin
        cnt_bad = (cnt_in == '0) || (int'(cnt_in) > DEPTH);
    end

    // PEC enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_pec <= 1'b0;
        end else if (aux_we) begin
            aux_pec <= wdata[AUX_PEC_BIT];
        end
    end

    if (BUF_PRESENT) begin : g_buf
        // Buffer enable bit, present only when the store is built
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aux_buf <= 1'b0;
            end else if (aux_we) begin
                aux_buf <= wdata[AUX_BUF_BIT];
            end
        end
    end else begin : g_nobuf
        assign aux_buf = 1'b0;
    end

    // Byte count: engine count has priority over software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data0 <= '0;
        end else if (cnt_we) begin
            data0 <= cnt_in;
        end else if (data0_we) begin
            data0 <= wdata;
        end
    end

    // Failure flag: cleared at start, set by an out-of-range count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_fail <= 1'b0;
        end else if (cnt_we && cnt_bad) begin
            proto_fail <= 1'b1;
        end else if (start) begin
            proto_fail <= 1'b0;
        end
    end
endmodule

// File: rtl/smbus_blkbuf.sv
// SMBus block data buffer top. Decodes the register accesses that concern
// the buffer, keeps one index for software and one for the engine, and
// routes payload bytes to and from the store. Buffer mode holds when the
// buffer enable bit is set and the transfer is not I2C style; otherwise
// entry 0 serves as a plain byte register. Read data for offsets not
// owned here is 0. Assumes one register access per cycle.
module smbus_blkbuf #(
    parameter int DEPTH       = 32,
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter bit BUF_PRESENT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          blk_i2c,
    input  logic          eng_start,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_byte,
    input  logic          eng_rx_valid,
    input  logic          eng_rx_first,
    input  logic [DW-1:0] eng_rx_byte,
    output logic [DW-1:0] eng_count,
    output logic          pec_en,
    output logic          proto_fail
);
    import smbb_pkg::*;

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          buffered;
    logic          aux_buf;
    logic          aux_pec;
    logic [DW-1:0] data0;
    logic          ctrl_rd, port_wr, port_rd, aux_wr, data0_wr;
    logic          rx_cnt, rx_pay;
    logic [IW-1:0] cpu_idx, eng_idx;
    logic          cpu_past, eng_past;
    logic          cpu_step, eng_step;
    logic          st_we;
    logic [IW-1:0] st_waddr, st_ra, st_rb;
    logic [DW-1:0] st_wdata, st_da, st_db;
    logic [DW-1:0] port_val;

    // Register access decode
    always_comb begin
        ctrl_rd  = cpu_rd && (cpu_addr == AW'(OFS_CTRL));
        port_rd  = cpu_rd && (cpu_addr == AW'(OFS_PORT));
        port_wr  = cpu_wr && (cpu_addr == AW'(OFS_PORT));
        aux_wr   = cpu_wr && (cpu_addr == AW'(OFS_AUX));
        data0_wr = cpu_wr && (cpu_addr == AW'(OFS_DATA0));
        rx_cnt   = eng_rx_valid && eng_rx_first;
        rx_pay   = eng_rx_valid && !eng_rx_first;
        buffered = aux_buf && !blk_i2c;
        cpu_step = buffered && (port_rd || port_wr);
        eng_step = buffered && (eng_tx_pop || rx_pay);
    end

    smbb_regs #(.DW(DW), .DEPTH(DEPTH), .BUF_PRESENT(BUF_PRESENT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .aux_we     (aux_wr),
        .data0_we   (data0_wr),
        .wdata      (cpu_wdata),
        .cnt_we     (rx_cnt),
        .cnt_in     (eng_rx_byte),
        .start      (eng_start),
        .aux_pec    (aux_pec),
        .aux_buf    (aux_buf),
        .data0      (data0),
        .proto_fail (proto_fail)
    );

    smbb_index #(.DEPTH(DEPTH)) u_cpu_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctrl_rd),
        .step     (cpu_step),
        .idx      (cpu_idx),
        .past_end (cpu_past)
    );

    smbb_index #(.DEPTH(DEPTH)) u_eng_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (eng_start),
        .step     (eng_step),
        .idx      (eng_idx),
        .past_end (eng_past)
    );

    // Store write arbitration: engine payload before software port writes
    always_comb begin
        st_we    = 1'b0;
        st_waddr = '0;
        st_wdata = cpu_wdata;
        if (rx_pay) begin
            st_we    = !(buffered && eng_past);
            st_waddr = buffered ? eng_idx : '0;
            st_wdata = eng_rx_byte;
        end else if (port_wr) begin
            st_we    = !(buffered && cpu_past);
            st_waddr = buffered ? cpu_idx : '0;
        end
        st_ra = buffered ? cpu_idx : '0;
        st_rb = buffered ? eng_idx : '0;
    end

    smbb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .raddr_a (st_ra),
        .rdata_a (st_da),
        .raddr_b (st_rb),
        .rdata_b (st_db)
    );

    // Read data: past-end reads return 0
    always_comb begin
        port_val    = (buffered && cpu_past) ? '0 : st_da;
        eng_tx_byte = (buffered && eng_past) ? '0 : st_db;
        cpu_rdata   = '0;
        if (cpu_addr == AW'(OFS_DATA0)) begin
            cpu_rdata = data0;
        end else if (cpu_addr == AW'(OFS_PORT)) begin
            cpu_rdata = port_val;
        end else if (cpu_addr == AW'(OFS_AUX)) begin
            cpu_rdata[AUX_PEC_BIT] = aux_pec;
            cpu_rdata[AUX_BUF_BIT] = aux_buf;
        end
    end

    // Engine-facing outputs
    always_comb begin
        eng_count = data0;
        pec_en    = aux_pec;
    end
endmodule

// File: rtl/smbb_chk.sv
// Property checker for smbus_blkbuf, attached with bind below. Watches
// ports and the two index states; adds no logic to the design.
module smbb_chk #(
    parameter int DEPTH       = 32,
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter bit BUF_PRESENT = 1'b1,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [DW-1:0] cpu_wdata,
    input logic [DW-1:0] cpu_rdata,
    input logic          blk_i2c,
    input logic          eng_start,
    input logic          eng_rx_valid,
    input logic          eng_rx_first,
    input logic [DW-1:0] eng_rx_byte,
    input logic [DW-1:0] eng_count,
    input logic          pec_en,
    input logic          proto_fail,
    input logic          aux_buf,
    input logic [IW-1:0] cpu_idx,
    input logic          cpu_past
);
    import smbb_pkg::*;

    // R2: auxiliary bits follow the written value
    a_r2_aux_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == AW'(OFS_AUX)) |=>
        (pec_en == $past(cpu_wdata[AUX_PEC_BIT]) &&
         aux_buf == ($past(cpu_wdata[AUX_BUF_BIT]) && BUF_PRESENT)));

    // R3: control read rewinds the software index
    a_r3_ctrl_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == AW'(OFS_CTRL)) |=> (cpu_idx == '0 && !cpu_past));

    // R5: received count lands in data0
    a_r5_count_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && eng_rx_first) |=> (eng_count == $past(eng_rx_byte)));

    // R6: out-of-range count raises the failure flag
    a_r6_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && eng_rx_first &&
         (eng_rx_byte == '0 || int'(eng_rx_byte) > DEPTH)) |=> proto_fail);

    // R6: start clears the failure flag when no count arrives with it
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !(eng_rx_valid && eng_rx_first)) |=> !proto_fail);

    // R7: a port read past the end returns 0
    a_r7_past_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_buf && !blk_i2c && cpu_past && cpu_rd && cpu_addr == AW'(OFS_PORT))
        |-> (cpu_rdata == '0));

    // R8: without buffer mode, port accesses leave the index alone
    a_r8_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((!aux_buf || blk_i2c) && (cpu_rd || cpu_wr) && cpu_addr == AW'(OFS_PORT))
        |=> ($stable(cpu_idx) && $stable(cpu_past)));
endmodule

bind smbus_blkbuf smbb_chk #(
    .DEPTH(DEPTH), .DW(DW), .AW(AW), .BUF_PRESENT(BUF_PRESENT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .blk_i2c      (blk_i2c),
    .eng_start    (eng_start),
    .eng_rx_valid (eng_rx_valid),
    .eng_rx_first (eng_rx_first),
    .eng_rx_byte  (eng_rx_byte),
    .eng_count    (eng_count),
    .pec_en       (pec_en),
    .proto_fail   (proto_fail),
    .aux_buf      (aux_buf),
    .cpu_idx      (cpu_idx),
    .cpu_past     (cpu_past)
);

// File: tb/sim_smbus_blkbuf.sv
// Self-checking bench for smbus_blkbuf: random payloads plus directed ends.
module sim_smbus_blkbuf;
    localparam int CLK_NS = 8;
    localparam int DEPTH  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       blk_i2c = 1'b0;
    logic       eng_start = 1'b0, eng_tx_pop = 1'b0;
    logic [7:0] eng_tx_byte;
    logic       eng_rx_valid = 1'b0, eng_rx_first = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic [7:0] eng_count;
    logic       pec_en, proto_fail;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pay [40];
    logic [7:0] got;

    always #(CLK_NS/2) clk = ~clk;

    smbus_blkbuf u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .blk_i2c(blk_i2c), .eng_start(eng_start), .eng_tx_pop(eng_tx_pop),
        .eng_tx_byte(eng_tx_byte), .eng_rx_valid(eng_rx_valid),
        .eng_rx_first(eng_rx_first), .eng_rx_byte(eng_rx_byte),
        .eng_count(eng_count), .pec_en(pec_en), .proto_fail(proto_fail)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic count_bad(input logic [7:0] c);
        return (c == 8'd0) || (int'(c) > DEPTH);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); eng_start = 1'b1;
        @(negedge clk); eng_start = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); eng_tx_pop = 1'b1;
        #1 d = eng_tx_byte;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    task automatic rx(input logic first, input logic [7:0] b);
        @(negedge clk); eng_rx_valid = 1'b1; eng_rx_first = first; eng_rx_byte = b;
        @(negedge clk); eng_rx_valid = 1'b0; eng_rx_first = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd5, got); check("R1 data0", got, 8'h00);
        rd(4'd13, got); check("R1 aux", got, 8'h00);
        check("R1 pec_en", {7'b0, pec_en}, 8'h00);
        check("R1 proto_fail", {7'b0, proto_fail}, 8'h00);

        // R2: auxiliary bits
        wr(4'd13, 8'h03); rd(4'd13, got); check("R2 aux=3", got, 8'h03);
        check("R2 pec_en on", {7'b0, pec_en}, 8'h01);
        wr(4'd13, 8'h00); rd(4'd13, got); check("R2 aux clear", got, 8'h00);
        check("R2 pec_en off", {7'b0, pec_en}, 8'h00);
        wr(4'd13, 8'h02); rd(4'd13, got); check("R2 buf readback", got, 8'h02);

        // R4: random block writes drained by the engine
        for (int r = 0; r < 4; r++) begin
            int len;
            len = (r == 0) ? 1 : 1 + int'($urandom % DEPTH);
            rd(4'd2, got);
            wr(4'd5, 8'(len));
            for (int i = 0; i < len; i++) begin
                pay[i] = 8'($urandom);
                wr(4'd7, pay[i]);
            end
            go();
            check("R4 eng_count", eng_count, 8'(len));
            for (int i = 0; i < len; i++) begin
                pop(got); check("R4 tx byte", got, pay[i]);
            end
        end

        // R3: control read rewinds (buffer still holds last payload)
        wr(4'd5, 8'd0);
        rd(4'd2, got);
        for (int i = 0; i < 2; i++) wr(4'd7, 8'hA0 + 8'(i));
        rd(4'd2, got);
        rd(4'd7, got); check("R3 first after rewind", got, 8'hA0);
        rd(4'd7, got); check("R3 second", got, 8'hA1);
        rd(4'd2, got);
        rd(4'd7, got); check("R3 rewind again", got, 8'hA0);

        // R5/R6: random block reads
        for (int r = 0; r < 4; r++) begin
            int len;
            len = (r == 0) ? DEPTH : 1 + int'($urandom % DEPTH);
            go();
            rx(1'b1, 8'(len));
            for (int i = 0; i < len; i++) begin
                pay[i] = 8'($urandom);
                rx(1'b0, pay[i]);
            end
            check("R6 valid count no fail", {7'b0, proto_fail}, {7'b0, count_bad(8'(len))});
            rd(4'd2, got);
            rd(4'd5, got); check("R5 data0 count", got, 8'(len));
            for (int i = 0; i < len; i++) begin
                rd(4'd7, got); check("R5 rx byte", got, pay[i]);
            end
        end

        // R6: out-of-range counts
        go(); rx(1'b1, 8'd0);
        check("R6 count 0", {7'b0, proto_fail}, {7'b0, count_bad(8'd0)});
        go(); check("R6 start clears", {7'b0, proto_fail}, 8'h00);
        rx(1'b1, 8'd33);
        check("R6 count 33", {7'b0, proto_fail}, {7'b0, count_bad(8'd33)});
        go(); rx(1'b1, 8'd32);
        check("R6 count 32", {7'b0, proto_fail}, 8'h00);

        // R7: software past-end writes and reads
        rd(4'd2, got);
        for (int i = 0; i < DEPTH; i++) begin
            pay[i] = 8'($urandom);
            wr(4'd7, pay[i]);
        end
        wr(4'd7, ~pay[DEPTH-1]);
        rd(4'd2, got);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd7, got); check("R7 full buffer", got, pay[i]);
        end
        rd(4'd7, got); check("R7 read past end", got, 8'h00);
        go();
        for (int i = 0; i < DEPTH; i++) pop(got);
        pop(got); check("R7 pop past end", got, 8'h00);

        // R7: engine payload beyond 32 not stored
        go(); rx(1'b1, 8'd34);
        for (int i = 0; i < DEPTH + 2; i++) begin
            pay[i] = 8'($urandom);
            rx(1'b0, pay[i]);
        end
        rd(4'd2, got);
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'd7, got); check("R7 rx truncated", got, pay[i]);
        end

        // R8: I2C style transfer, port is a single register
        blk_i2c = 1'b1;
        wr(4'd7, 8'h5A); wr(4'd7, 8'hC3);
        rd(4'd7, got); check("R8 i2c last byte", got, 8'hC3);
        rd(4'd7, got); check("R8 i2c no step", got, 8'hC3);
        blk_i2c = 1'b0;
        // R8: buffer mode off
        wr(4'd13, 8'h00);
        wr(4'd7, 8'h11); wr(4'd7, 8'h22);
        rd(4'd7, got); check("R8 off last byte", got, 8'h22);
        rd(4'd7, got); check("R8 off no step", got, 8'h22);
        go(); pop(got); check("R8 off engine byte", got, 8'h22);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule